// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines and presents them to up to four processors. Each source carries a global enable, a per-processor mask and a routing bitmap. A source is eligible for a processor when its line is high, it is enabled, its routing bit for that processor is set and that processor has not masked it. Each processor has its own interrupt output. It reads an acknowledge register to learn which source to service. Enables and masks are changed by writing a source number to a set register or a clear register. No bitmap is read, modified and written back.

The register bus has two windows, chosen by `bus_win`. The shared window holds the source count, the enable set and clear registers, a doorbell trigger and one control word per source. The per-processor window is addressed by `bus_cpu` and holds the mask set and clear registers, the doorbell cause register and the acknowledge register. Doorbells are inter-processor signals. Acknowledge ID 0 is reserved for them. ID 1023 means nothing is pending. Source IDs run from 1 to the source count, and input bit k is source ID k+1. Read data is combinational in the cycle `bus_rd` is high. Writes take effect at the next clock edge.

Top module: `irq_mp_ctrl`

## Requirements
- R1: While reset is held and after it is released, all enables are clear and all masks are set. Every source control word reads 1, meaning it is routed to processor 0. Every doorbell cause reads 0, every acknowledge reads 1023 and every interrupt output is low.
- R2: A shared-window write to offset 0x30 sets the enable of the source whose ID is in write data bits [9:0]. A write to offset 0x34 clears that enable.
- R3: A per-processor write to offset 0x48 masks the source ID in data bits [9:0] for the processor selected by `bus_cpu` only. A write to offset 0x4C unmasks it.
- R4: Shared offset 0x100 + 4×ID is the control word of source ID. Its bits [NUM_CPU-1:0] form the routing bitmap, where bit c routes the source to processor c. The word reads back what was written, with all other bits zero.
- R5: A shared read of offset 0x00 returns the source count in bits [11:2] and zero elsewhere.
- R6: A per-processor read of offset 0x44 returns the lowest eligible source ID for that processor in bits [9:0], with zero above.
- R7: The acknowledge read returns 1023 when no source is eligible and no doorbell is pending for that processor.
- R8: A shared write to offset 0x04 sets doorbell bit data[2:0] for every processor c whose bit data[8+c] is set. The per-processor cause register at offset 0x08 shows bits [7:0]. Writing 1s to it clears those bits. While any cause bit of a processor is set, its acknowledge reads 0.
- R9: Pending state follows the source level. A source drops out of the acknowledge as soon as its line falls. Reading the acknowledge changes nothing.
- R10: Each interrupt output `irq_o[c]` is high exactly when the acknowledge of processor c is not 1023.
- R11: Writes naming source ID 0 or an ID above the source count change no state. Control-word reads for such IDs return 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level interrupt lines, bit k is source ID k+1 |
| bus_cpu | input | 2 | Processor selected for the per-processor window |
| bus_win | input | 1 | 0 selects the shared window, 1 the per-processor window |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_o | output | NUM_CPU | Interrupt request per processor |

## Verification
A wrong enable, mask or routing bit is invisible until its source line rises. From that point the wrong processor's output changes in the same cycle, and its acknowledge shows a different ID on the next read. A lost or stuck doorbell cause bit shows at once, because it forces acknowledge 0 and holds the output high. The bench therefore compares every interrupt output on every clock against a behavioural model and checks every read against it. Random phases toggle the source lines so that latent state errors surface at the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int ID_W      = 10;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int CPU_SEL_W = 2;
    localparam int DB_W      = 8;

    localparam logic [ID_W-1:0] NONE_ID = 10'd1023;
    localparam logic [ID_W-1:0] BELL_ID = 10'd0;

    // shared window
    localparam logic [ADDR_W-1:0] SH_INFO    = 12'h000;
    localparam logic [ADDR_W-1:0] SH_BELL    = 12'h004;
    localparam logic [ADDR_W-1:0] SH_EN_SET  = 12'h030;
    localparam logic [ADDR_W-1:0] SH_EN_CLR  = 12'h034;
    localparam logic [ADDR_W-1:0] SH_CW_BASE = 12'h100;
    // per-processor window
    localparam logic [ADDR_W-1:0] PC_CAUSE   = 12'h008;
    localparam logic [ADDR_W-1:0] PC_ACK     = 12'h044;
    localparam logic [ADDR_W-1:0] PC_MSK_SET = 12'h048;
    localparam logic [ADDR_W-1:0] PC_MSK_CLR = 12'h04C;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR,
        OP_ROUTE_WR,
        OP_BELL,
        OP_CAUSE_CLR
    } op_e;

    typedef struct packed {
        op_e                   op;
        logic [ID_W-1:0]       id;
        logic [CPU_SEL_W-1:0]  cpu;
        logic [DATA_W-1:0]     data;
    } cmd_t;

    function automatic logic id_in_range(logic [ID_W-1:0] id, int nsrc);
        return (id != '0) && (int'(id) <= nsrc);
    endfunction

    // control word offset to source ID; caller checks alignment and base
    function automatic logic [ID_W-1:0] cw_id(logic [ADDR_W-1:0] addr);
        return addr[ADDR_W-1:2] - 10'd64;
    endfunction

    function automatic logic is_cw_addr(logic [ADDR_W-1:0] addr, int nsrc);
        return (addr >= SH_CW_BASE) && (addr[1:0] == 2'b00) &&
               id_in_range(cw_id(addr), nsrc);
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4
) (
    input  logic                  wr,
    input  logic                  win,
    input  logic [CPU_SEL_W-1:0]  cpu,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output cmd_t                  cmd
);

    logic [ID_W-1:0] data_id;
    logic            cpu_ok;

    assign data_id = wdata[ID_W-1:0];
    assign cpu_ok  = int'(cpu) < NUM_CPU;

    always_comb begin
        cmd.op   = OP_NONE;
        cmd.id   = data_id;
        cmd.cpu  = cpu;
        cmd.data = wdata;
        if (wr) begin
            if (!win) begin
                if (addr == SH_EN_SET && id_in_range(data_id, NUM_SRC)) begin
                    cmd.op = OP_EN_SET;
                end else if (addr == SH_EN_CLR && id_in_range(data_id, NUM_SRC)) begin
                    cmd.op = OP_EN_CLR;
                end else if (addr == SH_BELL) begin
                    cmd.op = OP_BELL;
                end else if (is_cw_addr(addr, NUM_SRC)) begin
                    cmd.op = OP_ROUTE_WR;
                    cmd.id = cw_id(addr);
                end
            end else if (cpu_ok) begin
                if (addr == PC_MSK_SET && id_in_range(data_id, NUM_SRC)) begin
                    cmd.op = OP_MSK_SET;
                end else if (addr == PC_MSK_CLR && id_in_range(data_id, NUM_SRC)) begin
                    cmd.op = OP_MSK_CLR;
                end else if (addr == PC_CAUSE) begin
                    cmd.op = OP_CAUSE_CLR;
                end
            end
        end
    end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  cmd_t                               cmd,
    input  logic [NUM_SRC-1:0]                 lvl,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]    route_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]    elig
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CPUW  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    logic [NUM_SRC-1:0]              en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
    logic [ID_W-1:0]                 idx_full;
    logic [IDX_W-1:0]                idx;
    logic [CPUW-1:0]                 cpu_i;

    assign idx_full = cmd.id - 10'd1;
    assign idx      = idx_full[IDX_W-1:0];
    assign cpu_i    = cmd.cpu[CPUW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mask_q <= '1;
            for (int s = 0; s < NUM_SRC; s++) begin
                route_q[s] <= NUM_CPU'(1);
            end
        end else begin
            case (cmd.op)
                OP_EN_SET:   en_q[idx]          <= 1'b1;
                OP_EN_CLR:   en_q[idx]          <= 1'b0;
                OP_MSK_SET:  mask_q[cpu_i][idx] <= 1'b1;
                OP_MSK_CLR:  mask_q[cpu_i][idx] <= 1'b0;
                OP_ROUTE_WR: route_q[idx]       <= cmd.data[NUM_CPU-1:0];
                default: ;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_elig
        always_comb begin
            for (int s = 0; s < NUM_SRC; s++) begin
                elig[c][s] = lvl[s] & en_q[s] & ~mask_q[c][s] & route_q[s][c];
            end
        end
    end

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_EN_SET |=> en_q[$past(idx)]);

    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_EN_CLR |=> !en_q[$past(idx)]);

    // R3
    msk_set_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_MSK_SET |=> mask_q[$past(cpu_i)][$past(idx)]);

    // R11
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op != OP_EN_SET && cmd.op != OP_EN_CLR) |=> $stable(en_q));

endmodule

// File: rtl/irq_bell.sv
module irq_bell
    import irq_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  cmd_t                           cmd,
    output logic [NUM_CPU-1:0][DB_W-1:0]   cause_q,
    output logic [NUM_CPU-1:0]             bell_any
);

    localparam int CPUW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    logic [2:0]      bell_no;
    logic [CPUW-1:0] cpu_i;

    assign bell_no = cmd.data[2:0];
    assign cpu_i   = cmd.cpu[CPUW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else if (cmd.op == OP_BELL) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (cmd.data[8+c]) cause_q[c][bell_no] <= 1'b1;
            end
        end else if (cmd.op == OP_CAUSE_CLR) begin
            cause_q[cpu_i] <= cause_q[cpu_i] & ~cmd.data[DB_W-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_any
        assign bell_any[c] = |cause_q[c];
    end

    // R8
    bell_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_BELL && cmd.data[8]) |=> cause_q[0][$past(bell_no)]);

    // R8
    bell_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_CAUSE_CLR) |=>
            ((cause_q[$past(cpu_i)] & $past(cmd.data[DB_W-1:0])) == '0));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic               bell,
    output logic [ID_W-1:0]    id
);

    always_comb begin
        id = NONE_ID;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (req[s]) id = ID_W'(s + 1);
        end
        if (bell) id = BELL_ID;
    end

endmodule

// File: rtl/irq_mp_ctrl.sv
module irq_mp_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic [1:0]            bus_cpu,
    input  logic                  bus_win,
    input  logic [11:0]           bus_addr,
    input  logic                  bus_wr,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_rd,
    output logic [31:0]           bus_rdata,
    output logic [NUM_CPU-1:0]    irq_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CPUW  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    cmd_t                               cmd;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]    route_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]    elig;
    logic [NUM_CPU-1:0][DB_W-1:0]       cause_q;
    logic [NUM_CPU-1:0]                 bell_any;
    logic [NUM_CPU-1:0][ID_W-1:0]       ack_id;

    irq_bus_decode #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_dec (
        .wr(bus_wr), .win(bus_win), .cpu(bus_cpu), .addr(bus_addr),
        .wdata(bus_wdata), .cmd(cmd)
    );

    irq_src_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_bank (
        .clk(clk), .rst(rst), .cmd(cmd), .lvl(src_i),
        .route_q(route_q), .elig(elig)
    );

    irq_bell #(.NUM_CPU(NUM_CPU)) u_bell (
        .clk(clk), .rst(rst), .cmd(cmd), .cause_q(cause_q), .bell_any(bell_any)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .req(elig[c]), .bell(bell_any[c]), .id(ack_id[c])
        );
        assign irq_o[c] = (|elig[c]) | bell_any[c];

        // R10
        irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
            irq_o[c] == (ack_id[c] != NONE_ID));

        // R8
        ack_bell_chk: assert property (@(posedge clk) disable iff (rst)
            (ack_id[c] == BELL_ID) |-> (cause_q[c] != '0));

        // R6
        ack_range_chk: assert property (@(posedge clk) disable iff (rst)
            (ack_id[c] == NONE_ID) || (int'(ack_id[c]) <= NUM_SRC));
    end

    // read path
    logic [ID_W-1:0]  rd_full;
    logic [IDX_W-1:0] rd_idx;
    logic [CPUW-1:0]  rd_cpu;
    logic             rd_cpu_ok;

    assign rd_full   = cw_id(bus_addr) - 10'd1;
    assign rd_idx    = rd_full[IDX_W-1:0];
    assign rd_cpu    = bus_cpu[CPUW-1:0];
    assign rd_cpu_ok = int'(bus_cpu) < NUM_CPU;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (!bus_win) begin
                if (bus_addr == SH_INFO) begin
                    bus_rdata[11:2] = 10'(NUM_SRC);
                end else if (is_cw_addr(bus_addr, NUM_SRC)) begin
                    bus_rdata[NUM_CPU-1:0] = route_q[rd_idx];
                end
            end else if (rd_cpu_ok) begin
                if (bus_addr == PC_ACK) begin
                    bus_rdata[ID_W-1:0] = ack_id[rd_cpu];
                end else if (bus_addr == PC_CAUSE) begin
                    bus_rdata[DB_W-1:0] = cause_q[rd_cpu];
                end
            end
        end
    end

endmodule

// File: tb/tb_irq_mp_ctrl.sv
module tb_irq_mp_ctrl;

    localparam int N  = 32;
    localparam int NC = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    src_i = '0;
    logic [1:0]      bus_cpu = '0;
    logic            bus_win = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_rd = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit run_chk = 0;

    // behavioural model
    bit       m_en   [1:N];
    bit       m_mask [0:NC-1][1:N];
    bit [3:0] m_route[1:N];
    bit [7:0] m_cause[0:NC-1];

    irq_mp_ctrl #(.NUM_SRC(N), .NUM_CPU(NC)) dut (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_cpu(bus_cpu), .bus_win(bus_win),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_ack(int c);
        if (m_cause[c] != 0) return 0;
        for (int id = 1; id <= N; id++) begin
            if (src_i[id-1] && m_en[id] && !m_mask[c][id] && m_route[id][c]) return id;
        end
        return 1023;
    endfunction

    function automatic int exp_rd(bit win, int cpu, int addr);
        if (!win) begin
            if (addr == 0) return N << 2;
            if (addr >= 'h100 && addr % 4 == 0) begin
                int id = (addr - 'h100) / 4;
                if (id >= 1 && id <= N) return int'(m_route[id]);
            end
            return 0;
        end
        if (cpu >= NC) return 0;
        if (addr == 'h44) return exp_ack(cpu);
        if (addr == 'h08) return int'(m_cause[cpu]);
        return 0;
    endfunction

    task automatic model_reset();
        for (int id = 1; id <= N; id++) begin
            m_en[id] = 0;
            m_route[id] = 4'b0001;
            for (int c = 0; c < NC; c++) m_mask[c][id] = 1;
        end
        for (int c = 0; c < NC; c++) m_cause[c] = 0;
    endtask

    task automatic model_write(bit win, int cpu, int addr, logic [31:0] d);
        int id = int'(d[9:0]);
        bit ok = (id >= 1 && id <= N);
        if (!win) begin
            if (addr == 'h30 && ok) m_en[id] = 1;
            else if (addr == 'h34 && ok) m_en[id] = 0;
            else if (addr == 'h04) begin
                for (int c = 0; c < NC; c++) if (d[8+c]) m_cause[c][d[2:0]] = 1;
            end else if (addr >= 'h100 && addr % 4 == 0) begin
                int cid = (addr - 'h100) / 4;
                if (cid >= 1 && cid <= N) m_route[cid] = d[3:0];
            end
        end else if (cpu < NC) begin
            if (addr == 'h48 && ok) m_mask[cpu][id] = 1;
            else if (addr == 'h4C && ok) m_mask[cpu][id] = 0;
            else if (addr == 'h08) m_cause[cpu] = m_cause[cpu] & ~d[7:0];
        end
    endtask

    // model update and per-clock output compare
    always @(posedge clk) begin
        if (rst) model_reset();
        else if (bus_wr) model_write(bus_win, int'(bus_cpu), int'(bus_addr), bus_wdata);
        #2;
        if (run_chk) begin
            for (int c = 0; c < NC; c++) begin
                // R10 and R1 (outputs low after reset)
                chk($sformatf("R10 irq_o[%0d]", c), int'(irq_o[c]), int'(exp_ack(c) != 1023));
            end
        end
    end

    task automatic wr(bit win, int cpu, int addr, logic [31:0] d);
        @(negedge clk);
        bus_win = win; bus_cpu = 2'(cpu); bus_addr = 12'(addr); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(bit win, int cpu, int addr, string tag);
        @(negedge clk);
        bus_win = win; bus_cpu = 2'(cpu); bus_addr = 12'(addr); bus_rd = 1'b1;
        #1;
        chk(tag, int'(bus_rdata), exp_rd(win, cpu, addr));
        bus_rd = 1'b0;
    endtask

    task automatic set_src(int id, bit v);
        @(negedge clk);
        src_i[id-1] = v;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_chk = 1;
        // R1 reset state, directed literal values too
        @(negedge clk); bus_win = 1; bus_cpu = 0; bus_addr = 12'h044; bus_rd = 1; #1;
        chk("R1 ack after reset", int'(bus_rdata), 1023); bus_rd = 0;
        @(negedge clk); bus_win = 0; bus_addr = 12'h104; bus_rd = 1; #1;
        chk("R1 route of ID1 after reset", int'(bus_rdata), 1); bus_rd = 0;
        rd(0, 0, 'h000, "R5 source count");
        @(negedge clk); bus_win = 0; bus_addr = 12'h000; bus_rd = 1; #1;
        chk("R5 source count literal", int'(bus_rdata), N * 4); bus_rd = 0;
        for (int c = 0; c < NC; c++) begin
            rd(1, c, 'h44, "R7 ack idle");
            rd(1, c, 'h08, "R1 cause after reset");
        end
        rd(0, 0, 'h100 + 4 * N, "R1 route of last ID");
        // R1: lines high but nothing enabled
        set_src(3, 1); set_src(5, 1);
        rd(1, 0, 'h44, "R1 masked and disabled");
        // R2 R3 R6
        wr(0, 0, 'h30, 5); wr(0, 0, 'h30, 3);
        wr(1, 0, 'h4C, 3); wr(1, 0, 'h4C, 5);
        rd(1, 0, 'h44, "R6 lowest eligible");
        @(negedge clk); bus_win = 1; bus_cpu = 0; bus_addr = 12'h044; bus_rd = 1; #1;
        chk("R6 lowest eligible literal", int'(bus_rdata), 3); bus_rd = 0;
        rd(1, 1, 'h44, "R3 other cpu unaffected");
        // R9
        rd(1, 0, 'h44, "R9 ack read has no side effect");
        set_src(3, 0);
        rd(1, 0, 'h44, "R9 level drop");
        wr(0, 0, 'h34, 5);
        rd(1, 0, 'h44, "R2 enable clear");
        // R4 routing
        wr(0, 0, 'h100 + 4 * 7, 4);
        rd(0, 0, 'h100 + 4 * 7, "R4 route readback");
        wr(0, 0, 'h30, 7); wr(1, 2, 'h4C, 7); set_src(7, 1);
        rd(1, 2, 'h44, "R4 routed to cpu2");
        rd(1, 0, 'h44, "R4 not routed to cpu0");
        wr(1, 2, 'h48, 7);
        rd(1, 2, 'h44, "R3 mask set");
        // R11 invalid IDs
        wr(0, 0, 'h30, 0); wr(0, 0, 'h30, N + 1); wr(1, 2, 'h4C, 0);
        wr(0, 0, 'h100 + 4 * (N + 1), 15);
        rd(0, 0, 'h100, "R11 ID0 control word");
        rd(0, 0, 'h100 + 4 * (N + 1), "R11 out of range control word");
        rd(0, 0, 'h30, "R11 unmapped read");
        rd(1, 2, 'h44, "R11 no state change");
        // boundary: highest ID
        wr(0, 0, 'h30, N); wr(1, 0, 'h4C, N); set_src(N, 1);
        rd(1, 0, 'h44, "R6 highest ID");
        // R8 doorbells
        set_src(5, 1); wr(0, 0, 'h30, 5);
        wr(0, 0, 'h04, 32'h0000_0303);
        rd(1, 0, 'h44, "R8 doorbell ack 0");
        rd(1, 1, 'h44, "R8 doorbell cpu1");
        rd(1, 0, 'h08, "R8 cause bits");
        rd(1, 2, 'h08, "R8 untargeted cpu");
        wr(1, 0, 'h08, 32'h08);
        rd(1, 0, 'h44, "R8 cleared back to source");
        rd(1, 1, 'h44, "R8 other cpu still rung");
        // random phase
        for (int i = 0; i < 1500; i++) begin
            int k = $urandom_range(0, 9);
            int id = $urandom_range(0, N + 2);
            int c = $urandom_range(0, NC - 1);
            case (k)
                0: wr(0, 0, 'h30, id);
                1: wr(0, 0, 'h34, id);
                2: wr(1, c, 'h48, id);
                3: wr(1, c, 'h4C, id);
                4: wr(0, 0, 'h100 + 4 * id, $urandom_range(0, 15));
                5: wr(0, 0, 'h04, ($urandom_range(0, 15) << 8) | $urandom_range(0, 7));
                6: wr(1, c, 'h08, $urandom_range(0, 255));
                7: begin @(negedge clk); src_i = $urandom(); end
                8: rd(1, c, 'h44, "R6 random ack");
                default: rd(0, 0, 'h100 + 4 * id, "R4 random route");
            endcase
        end
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule